// File: doc/BRIEF.md
# Dynamic Read/Write Bus Sizer

This block sits between a 32-bit processor bus and a peripheral bus. The peripheral may turn out to be 8, 16 or 32 bits wide. The width is not configured anywhere. On every access the block learns it from the two-bit size code that the peripheral returns with its acknowledge. A processor access opens when chip select is raised. The block then runs one, two or four peripheral transfers, each framed by a data strobe. For each transfer it presents the address of the first byte that transfer moves. It raises the byte write enables that fit the discovered width, and on reads it collects the returned bytes into their processor lanes. It closes the access with a single-cycle acknowledge to the processor.

The lower half of the processor data bus belongs to external transceivers when the port is 32 bits wide. The block therefore keeps its own lower-lane drive switched off until the width is known, and it does not drive those lanes at all for a 32-bit port. It supplies an enable and a direction for those transceivers. Write data on the two upper peripheral lanes follows from the address alone, so the data are already correct before the width is known.

Top module: `dyn_bus_sizer`

## Requirements
- R1: While reset is held, and after it is released with chip select low, the strobe, the processor acknowledge, all three write enables, the transceiver enable and the lower-lane enable are all 0.
- R2: The peripheral acknowledge code is 11 for a 32-bit port, 10 for a 16-bit port, 01 for an 8-bit port and 00 for a wait. An access of N bytes to a port of P bytes takes ceil(N/P) strobed transfers.
- R3: Each transfer presents on the peripheral address the byte address of the first byte it moves. The address advances by the number of bytes each transfer moved.
- R4: While the acknowledge code is 00 and chip select is high, the strobe stays high, the peripheral address holds and the access does not advance.
- R5: On reads, the byte at address a lands on processor lane bits [31-8a -: 8]. An 8-bit port delivers on peripheral bits [15:8]. A 16-bit port delivers even addresses on [15:8] and odd addresses on [7:0]. A 32-bit port delivers addresses 0 and 1 on [15:8] and [7:0]. All other processor bytes read as 0.
- R6: On writes, peripheral bits [15:8] carry the processor byte at the transfer address a, and bits [7:0] carry the byte at a|1. This holds whatever the port width.
- R7: Write enables are raised only on writes, in the cycle an acknowledge is present. The full-width enable is raised for a 32-bit port. For a 16-bit port, the upper enable is raised when the transfer moves an even-address byte and the lower enable when it moves an odd-address byte. For an 8-bit port, only the upper enable is raised.
- R8: The lower-lane enable is raised only on reads, only after the first acknowledge of the access, and only when the port is not 32 bits wide.
- R9: The transceiver enable is high at completion only for a 32-bit port. The transceiver direction equals the read flag (1 = read).
- R10: The processor acknowledge is a one-cycle pulse in the cycle after the acknowledge of the final transfer.
- R11: If chip select falls while a transfer is strobed, the strobe drops in the next cycle and no processor acknowledge is given.
- R12: The width decoded from the first acknowledge of an access governs the whole access. Later acknowledge codes only pace the transfers.
- R13: Transfer size code 01 is one byte, 10 is two bytes, and 00 and 11 are four bytes. Accesses are naturally aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 1 | Chip select, high opens and holds an access |
| cpu_addr | input | 2 | Low byte address of the access |
| cpu_size | input | 2 | Transfer size code |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Assembled read data, valid with cpu_ack |
| cpu_ack | output | 1 | Access complete pulse |
| cpu_lo_oe | output | 1 | Permission to drive processor lanes [15:0] |
| per_addr | output | 2 | Byte/word address of the current transfer |
| per_strobe | output | 1 | Transfer strobe |
| per_we_full | output | 1 | Write enable for a 32-bit port |
| per_we_hi | output | 1 | Write enable for peripheral lane [15:8] |
| per_we_lo | output | 1 | Write enable for peripheral lane [7:0] |
| per_ack | input | 2 | Acknowledge and port size code |
| per_wdata | output | 16 | Write data on the upper peripheral lanes |
| per_rdata | input | 16 | Read data from the upper peripheral lanes |
| xcvr_en | output | 1 | Lower-half transceiver enable |
| xcvr_dir | output | 1 | Lower-half transceiver direction |

## Verification
The hardest case to reach is an access whose peripheral changes its reported width after the first transfer. A well-behaved peripheral never does that, so the bench's peripheral model takes one acknowledge code for the first transfer and a separate one for the rest. That is how it shows the original split surviving. An abort is also hard to reach, because it needs chip select to fall while a strobe is still waiting. For that case the bench holds the peripheral in wait states long enough to drop the select in the middle of a transfer.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

   // Port width code as returned on the acknowledge lines
   typedef enum logic [1:0] {
      PW_NONE = 2'b00,
      PW_8    = 2'b01,
      PW_16   = 2'b10,
      PW_32   = 2'b11
   } port_w_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_XFER,
      ST_GAP,
      ST_DONE
   } seq_st_e;

   function automatic logic [2:0] port_bytes(port_w_e w);
      case (w)
         PW_8:    return 3'd1;
         PW_16:   return 3'd2;
         PW_32:   return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [2:0] req_bytes(logic [1:0] sz);
      case (sz)
         2'b01:   return 3'd1;
         2'b10:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/bsz_ctrl.sv
module bsz_ctrl
   import bsz_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [1:0]        size_in,
   input  logic              rd_in,
   input  logic [1:0]        ack_in,
   output logic              strobe,
   output logic              cpu_ack,
   output logic              busy,
   output logic              start,
   output logic              beat,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  step,
   output port_w_e           eff_w,
   output port_w_e           lk_w,
   output logic              known,
   output logic              rd_q
);

   seq_st_e          st;
   logic [CNT_W-1:0] rem;
   logic [CNT_W-1:0] wb;
   logic [CNT_W-1:0] off;
   logic [CNT_W-1:0] room;

   assign eff_w   = known ? lk_w : port_w_e'(ack_in);
   assign strobe  = (st == ST_XFER);
   assign cpu_ack = (st == ST_DONE);
   assign busy    = (st != ST_IDLE);
   assign start   = (st == ST_IDLE) && sel;
   assign beat    = strobe && sel && (ack_in != 2'b00);

   always_comb begin
      wb   = port_bytes(eff_w);
      off  = CNT_W'(cur_addr) & (wb - CNT_W'(1));
      room = wb - off;
      step = (rem < room) ? rem : room;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cur_addr <= '0;
         rem      <= '0;
         rd_q     <= 1'b0;
         known    <= 1'b0;
         lk_w     <= PW_NONE;
      end else begin
         case (st)
            ST_IDLE: begin
               if (sel) begin
                  cur_addr <= addr_in;
                  rem      <= req_bytes(size_in);
                  rd_q     <= rd_in;
                  known    <= 1'b0;
                  st       <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (!sel) begin
                  st <= ST_IDLE;
               end else if (beat) begin
                  if (!known) begin
                     known <= 1'b1;
                     lk_w  <= port_w_e'(ack_in);
                  end
                  cur_addr <= cur_addr + ADDR_W'(step);
                  rem      <= rem - step;
                  st       <= (rem == step) ? ST_DONE : ST_GAP;
               end
            end
            ST_GAP:  st <= sel ? ST_XFER : ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // wait code freezes the transfer
   assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && sel && ack_in == 2'b00) |=> (strobe && $stable(cur_addr)));

   // dropping the select while strobed abandons the access
   assert_abort_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !sel) |=> (!strobe && !cpu_ack));

   // width is frozen once learned
   assert_width_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (known && busy) |=> (lk_w == $past(lk_w)));

   // completion pulse follows a peripheral beat and lasts one cycle
   assert_ack_after_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> $past(beat));
   assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack);

endmodule

// File: rtl/bsz_wr_steer.sv
module bsz_wr_steer
   import bsz_pkg::*;
#(
   parameter int CPU_DW = 32,
   parameter int PER_DW = 16,
   parameter int ADDR_W = 2,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CPU_DW-1:0] cpu_wdata,
   input  logic              strobe,
   input  logic              sel,
   input  logic              rd_q,
   input  logic [1:0]        ack_in,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [CNT_W-1:0]  step,
   input  port_w_e           eff_w,
   output logic [PER_DW-1:0] per_wdata,
   output logic              we_full,
   output logic              we_hi,
   output logic              we_lo
);

   localparam int LANE = 8;

   logic [CPU_DW-1:0] wd_q;
   logic [ADDR_W-1:0] pair_addr;
   logic              act;

   function automatic logic [LANE-1:0] pick(logic [CPU_DW-1:0] w, logic [ADDR_W-1:0] a);
      return w[(CPU_DW-1) - LANE*int'(a) -: LANE];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wd_q <= '0;
      else if (start) wd_q <= cpu_wdata;
   end

   // address-only steering: valid for every port width
   assign pair_addr = cur_addr | ADDR_W'(1);
   assign per_wdata = {pick(wd_q, cur_addr), pick(wd_q, pair_addr)};

   assign act = strobe && sel && !rd_q && (ack_in != 2'b00);

   always_comb begin
      we_full = 1'b0;
      we_hi   = 1'b0;
      we_lo   = 1'b0;
      if (act) begin
         case (eff_w)
            PW_32: we_full = 1'b1;
            PW_16: begin
               we_hi = !cur_addr[0];
               we_lo = cur_addr[0] || (step >= CNT_W'(2));
            end
            PW_8:  we_hi = 1'b1;
            default: ;
         endcase
      end
   end

   // a lone lower enable only ever serves an odd byte
   assert_lo_only_odd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we_lo && !we_hi) |-> cur_addr[0]);

   // write lanes do not move during wait states
   assert_wdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && sel && ack_in == 2'b00) |=> $stable(per_wdata));

endmodule

// File: rtl/bsz_rd_assemble.sv
module bsz_rd_assemble
   import bsz_pkg::*;
#(
   parameter int CPU_DW = 32,
   parameter int PER_DW = 16,
   parameter int ADDR_W = 2,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              beat,
   input  logic              rd_q,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [CNT_W-1:0]  step,
   input  port_w_e           eff_w,
   input  logic [PER_DW-1:0] per_rdata,
   output logic [CPU_DW-1:0] rbuf
);

   localparam int LANE   = 8;
   localparam int NBYTES = CPU_DW / LANE;
   localparam int SPAN_W = CNT_W + 1;

   logic [LANE-1:0]   up_lane;
   logic [LANE-1:0]   dn_lane;
   logic [SPAN_W-1:0] span_lo;
   logic [SPAN_W-1:0] span_hi;

   assign up_lane = per_rdata[PER_DW-1 -: LANE];
   assign dn_lane = per_rdata[PER_DW-LANE-1 -: LANE];
   assign span_lo = SPAN_W'(cur_addr);
   assign span_hi = span_lo + SPAN_W'(step);

   for (genvar a = 0; a < NBYTES; a++) begin : g_byte
      logic            covered;
      logic            ok;
      logic [LANE-1:0] src;

      assign covered = (SPAN_W'(a) >= span_lo) && (SPAN_W'(a) < span_hi);

      always_comb begin
         src = up_lane;
         ok  = 1'b1;
         case (eff_w)
            PW_16: src = (a % 2 == 1) ? dn_lane : up_lane;
            PW_32: begin
               ok  = (a < 2);
               src = (a == 0) ? up_lane : dn_lane;
            end
            default: ;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rbuf[CPU_DW-1-LANE*a -: LANE] <= '0;
         else if (start)
            rbuf[CPU_DW-1-LANE*a -: LANE] <= '0;
         else if (beat && rd_q && covered && ok)
            rbuf[CPU_DW-1-LANE*a -: LANE] <= src;
      end
   end

endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
   import bsz_pkg::*;
#(
   parameter int CPU_DW = 32,
   parameter int PER_DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic [1:0]        cpu_addr,
   input  logic [1:0]        cpu_size,
   input  logic              cpu_rd,
   input  logic [CPU_DW-1:0] cpu_wdata,
   output logic [CPU_DW-1:0] cpu_rdata,
   output logic              cpu_ack,
   output logic              cpu_lo_oe,
   output logic [1:0]        per_addr,
   output logic              per_strobe,
   output logic              per_we_full,
   output logic              per_we_hi,
   output logic              per_we_lo,
   input  logic [1:0]        per_ack,
   output logic [PER_DW-1:0] per_wdata,
   input  logic [PER_DW-1:0] per_rdata,
   output logic              xcvr_en,
   output logic              xcvr_dir
);

   localparam int NBYTES = CPU_DW / 8;
   localparam int ADDR_W = $clog2(NBYTES);
   localparam int CNT_W  = ADDR_W + 1;

   if (CPU_DW != 32) begin : g_bad_cpu_dw
      $error("dyn_bus_sizer: CPU_DW must be 32");
   end
   if (PER_DW * 2 != CPU_DW) begin : g_bad_per_dw
      $error("dyn_bus_sizer: PER_DW must be half of CPU_DW");
   end

   logic              busy, start, beat, known, rd_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  step;
   port_w_e           eff_w, lk_w;

   bsz_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (cpu_sel),
      .addr_in  (cpu_addr),
      .size_in  (cpu_size),
      .rd_in    (cpu_rd),
      .ack_in   (per_ack),
      .strobe   (per_strobe),
      .cpu_ack  (cpu_ack),
      .busy     (busy),
      .start    (start),
      .beat     (beat),
      .cur_addr (cur_addr),
      .step     (step),
      .eff_w    (eff_w),
      .lk_w     (lk_w),
      .known    (known),
      .rd_q     (rd_q)
   );

   bsz_wr_steer #(.CPU_DW(CPU_DW), .PER_DW(PER_DW), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) wr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cpu_wdata (cpu_wdata),
      .strobe    (per_strobe),
      .sel       (cpu_sel),
      .rd_q      (rd_q),
      .ack_in    (per_ack),
      .cur_addr  (cur_addr),
      .step      (step),
      .eff_w     (eff_w),
      .per_wdata (per_wdata),
      .we_full   (per_we_full),
      .we_hi     (per_we_hi),
      .we_lo     (per_we_lo)
   );

   bsz_rd_assemble #(.CPU_DW(CPU_DW), .PER_DW(PER_DW), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) rd_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .beat      (beat),
      .rd_q      (rd_q),
      .cur_addr  (cur_addr),
      .step      (step),
      .eff_w     (eff_w),
      .per_rdata (per_rdata),
      .rbuf      (cpu_rdata)
   );

   assign per_addr  = cur_addr;
   assign cpu_lo_oe = busy && rd_q && known && (lk_w != PW_32);
   assign xcvr_en   = busy && (eff_w == PW_32);
   assign xcvr_dir  = rd_q;

   // lower lanes open only right after a peripheral has answered
   assert_lo_oe_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_lo_oe) |-> $past(beat));

   // no write strobe ever accompanies a read
   assert_no_we_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (per_we_full || per_we_hi || per_we_lo) |-> !xcvr_dir);

endmodule

// File: tb/dyn_bus_sizer_tb_top.sv
`timescale 1ns/1ps
module dyn_bus_sizer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_sel = 1'b0;
   logic [1:0]  cpu_addr = '0;
   logic [1:0]  cpu_size = '0;
   logic        cpu_rd = 1'b0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_ack, cpu_lo_oe;
   logic [1:0]  per_addr;
   logic        per_strobe, per_we_full, per_we_hi, per_we_lo;
   logic [1:0]  per_ack = '0;
   logic [15:0] per_wdata;
   logic [15:0] per_rdata = '0;
   logic        xcvr_en, xcvr_dir;

   always #10 clk = ~clk;

   dyn_bus_sizer dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
      .cpu_size(cpu_size), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_lo_oe(cpu_lo_oe),
      .per_addr(per_addr), .per_strobe(per_strobe), .per_we_full(per_we_full),
      .per_we_hi(per_we_hi), .per_we_lo(per_we_lo), .per_ack(per_ack),
      .per_wdata(per_wdata), .per_rdata(per_rdata), .xcvr_en(xcvr_en),
      .xcvr_dir(xcvr_dir)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // peripheral model controls, written by the main flow only
   logic [1:0] ack_first = 2'b00, ack_later = 2'b00, pdw = 2'b01;
   int         waits = 0;
   int         access_base = 0;
   bit         preset_req = 1'b0;
   logic [7:0] preset_val [4];

   // peripheral model state
   logic [7:0] mem [4];
   int         wcnt = 0;
   int         beat_total = 0;
   int         early_oe = 0;
   int         bad_we = 0;
   logic [1:0] first_pa = '0, last_pa = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // acknowledge and read-data side, driven away from the active edge
   always @(negedge clk) begin
      if (per_strobe) begin
         if (beat_total == access_base && cpu_lo_oe) early_oe++;
         if (wcnt >= waits) begin
            per_ack = (beat_total == access_base) ? ack_first : ack_later;
            if (beat_total == access_base) first_pa = per_addr;
            last_pa = per_addr;
            case (pdw)
               2'b01:   per_rdata = {mem[per_addr], 8'h5A};
               2'b10:   per_rdata = {mem[{per_addr[1], 1'b0}], mem[{per_addr[1], 1'b1}]};
               default: per_rdata = {mem[0], mem[1]};
            endcase
            beat_total++;
         end else begin
            per_ack = 2'b00;
         end
         wcnt++;
      end else begin
         per_ack = 2'b00;
         wcnt = 0;
      end
   end

   // storage side of the peripheral
   always @(posedge clk) begin
      if (preset_req) begin
         for (int a = 0; a < 4; a++) mem[a] <= preset_val[a];
      end else begin
         if ((per_we_full || per_we_hi || per_we_lo) && cpu_rd) bad_we <= bad_we + 1;
         if (per_we_full && pdw != 2'b11) bad_we <= bad_we + 1;
         if (per_we_full) begin
            mem[0] <= per_wdata[15:8];
            mem[1] <= per_wdata[7:0];
            mem[2] <= cpu_wdata[15:8];
            mem[3] <= cpu_wdata[7:0];
         end
         if (per_we_hi) begin
            if (pdw == 2'b01) mem[per_addr] <= per_wdata[15:8];
            else              mem[{per_addr[1], 1'b0}] <= per_wdata[15:8];
         end
         if (per_we_lo) mem[{per_addr[1], 1'b1}] <= per_wdata[7:0];
      end
   end

   function automatic int pbytes(input logic [1:0] c);
      return (c == 2'b11) ? 4 : (c == 2'b10) ? 2 : 1;
   endfunction
   function automatic int rbytes(input logic [1:0] s);   // R13 size codes
      return (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : 4;
   endfunction

   task automatic run_access(input logic rd, input logic [1:0] sz, input logic [1:0] ad,
                             input logic [1:0] c1, input logic [1:0] c2, input logic [1:0] pw,
                             input int wt, input int idx);
      logic [7:0]  pre [4];
      logic [31:0] wd, expd;
      logic [7:0]  exb;
      int n, pb, nx, stp, oe0, we0, lastx;
      bit seen;
      for (int a = 0; a < 4; a++) begin
         pre[a] = 8'(idx * 16 + a + 17);
         preset_val[a] = pre[a];
      end
      preset_req = 1'b1;
      @(negedge clk);
      preset_req = 1'b0;
      wd = 32'hC3D4E5F6 ^ 32'(idx);
      ack_first = c1; ack_later = c2; pdw = pw; waits = wt;
      access_base = beat_total; oe0 = early_oe; we0 = bad_we;
      cpu_rd = rd; cpu_size = sz; cpu_addr = ad; cpu_wdata = wd; cpu_sel = 1'b1;
      seen = 1'b0;
      for (int k = 0; k < 200 && !seen; k++) begin
         @(negedge clk);
         if (cpu_ack) seen = 1'b1;
      end
      chk(seen, "R10 completion acknowledge arrives", 32'(seen), 32'd1);
      n = rbytes(sz); pb = pbytes(c1);
      nx = (n + pb - 1) / pb; stp = (n < pb) ? n : pb;
      chk(beat_total - access_base == nx, "R2/R12 transfer count", 32'(beat_total - access_base), 32'(nx));
      chk(first_pa == ad, "R3 first transfer address", 32'(first_pa), 32'(ad));
      lastx = (ad + (nx - 1) * stp) % 4;
      chk(last_pa == 2'(lastx), "R3 last transfer address", 32'(last_pa), 32'(lastx));
      chk(cpu_lo_oe == (rd && c1 != 2'b11), "R8 lower lanes at completion", 32'(cpu_lo_oe), 32'(rd && c1 != 2'b11));
      chk(xcvr_en == (c1 == 2'b11) && xcvr_dir == rd, "R9 transceiver enable/direction",
          {30'd0, xcvr_en, xcvr_dir}, {30'd0, c1 == 2'b11, rd});
      if (rd) begin
         expd = '0;
         for (int a = 0; a < 4; a++)
            if (a >= ad && a < ad + n && (c1 != 2'b11 || a < 2))
               expd[31 - 8*a -: 8] = pre[a];
         chk(cpu_rdata == expd, "R5 assembled read data", cpu_rdata, expd);
      end
      cpu_sel = 1'b0;
      @(negedge clk);
      chk(!cpu_ack, "R10 acknowledge lasts one cycle", 32'(cpu_ack), 32'd0);
      if (!rd) begin
         for (int a = 0; a < 4; a++) begin
            exb = (a >= ad && a < ad + n) ? wd[31 - 8*a -: 8] : pre[a];
            chk(mem[a] == exb, "R6/R7 written byte", 32'(mem[a]), 32'(exb));
         end
      end
      chk(early_oe == oe0, "R8 lower lanes closed before first acknowledge", 32'(early_oe - oe0), 32'd0);
      chk(bad_we == we0, "R7 stray write enable", 32'(bad_we - we0), 32'd0);
   endtask

   // {rd, size, addr, ack code, waits}
   localparam int NV = 19;
   localparam logic [8:0] VEC [NV] = '{
      {1'b1, 2'b00, 2'd0, 2'b01, 2'd1},
      {1'b1, 2'b00, 2'd0, 2'b10, 2'd0},
      {1'b1, 2'b00, 2'd0, 2'b11, 2'd2},
      {1'b1, 2'b10, 2'd0, 2'b01, 2'd0},
      {1'b1, 2'b10, 2'd2, 2'b10, 2'd1},
      {1'b1, 2'b10, 2'd2, 2'b11, 2'd0},
      {1'b1, 2'b01, 2'd1, 2'b10, 2'd0},
      {1'b1, 2'b01, 2'd3, 2'b01, 2'd2},
      {1'b1, 2'b01, 2'd0, 2'b11, 2'd0},
      {1'b1, 2'b01, 2'd3, 2'b10, 2'd0},
      {1'b0, 2'b00, 2'd0, 2'b01, 2'd0},
      {1'b0, 2'b00, 2'd0, 2'b10, 2'd1},
      {1'b0, 2'b00, 2'd0, 2'b11, 2'd0},
      {1'b0, 2'b10, 2'd2, 2'b01, 2'd0},
      {1'b0, 2'b10, 2'd0, 2'b10, 2'd2},
      {1'b0, 2'b01, 2'd1, 2'b10, 2'd0},
      {1'b0, 2'b01, 2'd3, 2'b01, 2'd1},
      {1'b0, 2'b01, 2'd2, 2'b10, 2'd0},
      {1'b1, 2'b11, 2'd0, 2'b10, 2'd0}   // R13 size code 11 is four bytes
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(!per_strobe && !cpu_ack && !xcvr_en, "R1 idle during reset",
          {29'd0, per_strobe, cpu_ack, xcvr_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!per_strobe && !cpu_ack && !per_we_full && !per_we_hi && !per_we_lo && !xcvr_en && !cpu_lo_oe,
          "R1 idle after reset",
          {25'd0, per_strobe, cpu_ack, per_we_full, per_we_hi, per_we_lo, xcvr_en, cpu_lo_oe}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         run_access(VEC[i][8], VEC[i][7:6], VEC[i][5:4], VEC[i][3:2], VEC[i][3:2],
                    VEC[i][3:2], int'(VEC[i][1:0]), i);
      end

      // R4 / R11: hold in wait states, then drop the select mid-transfer
      ack_first = 2'b01; ack_later = 2'b01; pdw = 2'b01; waits = 50;
      access_base = beat_total;
      cpu_rd = 1'b1; cpu_size = 2'b01; cpu_addr = 2'd2; cpu_sel = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(per_strobe && per_addr == 2'd2, "R4 strobe and address held in wait",
             {29'd0, per_strobe, per_addr}, {29'd0, 1'b1, 2'd2});
      end
      cpu_sel = 1'b0;
      @(negedge clk);
      chk(!per_strobe, "R11 strobe drops after abort", 32'(per_strobe), 32'd0);
      begin
         bit acked = 1'b0;
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (cpu_ack) acked = 1'b1;
         end
         chk(!acked && beat_total == access_base, "R11 no acknowledge after abort", 32'(acked), 32'd0);
      end

      // R12: first answer says 8-bit, later answers claim 32-bit
      run_access(1'b1, 2'b00, 2'd0, 2'b01, 2'b11, 2'b01, 0, 40);
      // R12 on a write: first 16-bit, later 8-bit code
      run_access(1'b0, 2'b00, 2'd0, 2'b10, 2'b01, 2'b10, 1, 41);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule